// File: doc/BRIEF.md
# SPI Character Serializer with Bit-Order Reversal

This block turns a stream of transmit bytes into SPI characters of programmable length and shifts each character onto one serial data line, one bit per clock. The character length is the length setting plus one, from 4 to 16 bits. Characters of up to 8 bits take one byte each. Longer characters take two consecutive bytes: the first byte becomes the low eight bits and the low bits of the second byte become the upper part.

A reversal flag picks the bit order. When it is clear, a character goes out least significant bit first. When it is set, the character's bits are mirrored before shifting, so the most significant bit goes out first. Bytes enter through a valid/ready handshake. A one-character holding stage lets the next character start on the cycle after the last bit of the current one, with no idle cycle. A strobe marks every cycle that carries a bit on the line. A busy flag covers each character from its first bit to its last.

Top module: `spi_char_serializer`

## Requirements
- R1: After reset, serOut, shiftStb and busy are 0 and byteReady is 1.
- R2: For every charLen value from 3 to 15, each character puts exactly charLen+1 bits on serOut, each marked by one shiftStb cycle, with no padding bits.
- R3: charLen values 0, 1 and 2 give 4-bit characters.
- R4: For character lengths up to 8, each accepted byte forms one character, taken from its low (length) bits. Its upper bits are ignored. Characters leave in the order their bytes were accepted.
- R5: For character lengths above 8, two accepted bytes form one character. The first byte supplies bits 7..0. The low (length-8) bits of the second byte supply the upper bits. The remaining bits of the second byte are ignored.
- R6: With revOrder=0, character bit 0 is shifted first and the bits follow in ascending order.
- R7: With revOrder=1, the top bit of the character (bit length-1) is shifted first and the bits follow in descending order.
- R8: When the bytes of the next character are already available, its first bit follows the previous character's last bit on the next cycle, so shiftStb stays high throughout.
- R9: busy equals 1 exactly in the cycles that carry a character bit, and is 0 when no character is being shifted.
- R10: A byte is consumed only in a cycle with byteValid and byteReady both 1. While byteValid is 0 no new character starts, and a stalled stream resumes with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteData | input | 8 | Transmit byte |
| byteValid | input | 1 | byteData is offered |
| byteReady | output | 1 | Block can take a byte this cycle |
| charLen | input | 4 | Character length minus one (values below 3 act as 3) |
| revOrder | input | 1 | 1 = most significant bit first, 0 = least significant first |
| serOut | output | 1 | Serial data |
| shiftStb | output | 1 | serOut carries a valid bit this cycle |
| busy | output | 1 | A character is being shifted |

## Verification
The hardest situation to reach is a new character loading on the same cycle the previous one ends. The holding stage must be full exactly when the last bit of the running character goes out. This is also where a two-byte character could be corrupted if its low byte were captured too late. The bench keeps byteValid high for whole back-to-back streams of 4-, 8- and 13-bit characters, so the holding stage is always refilled before the shifter drains. It stamps each strobed bit with its cycle number and requires consecutive stamps across character boundaries. A separate stall scenario leaves long gaps between bytes, so the idle-to-load path is covered as well.

// File: rtl/spi_ser_pkg.sv
package spi_ser_pkg;
  typedef struct packed {
    logic captureLow;   // store first byte of a two-byte character
    logic capturePend;  // a full character enters the holding stage
    logic loadShift;    // holding stage moves into the shifter
    logic shiftEn;      // shifter advances one bit
  } serStrobes_t;
endpackage

// File: rtl/spi_ser_ctrl.sv
module spi_ser_ctrl
  import spi_ser_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int LEN_W   = 4,
  parameter int MIN_LEN = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] charLen,
  input  logic             byteValid,
  output logic             byteReady,
  output logic [LEN_W-1:0] effLen,
  output serStrobes_t      stb,
  output logic             active
);
  logic             haveLow;
  logic             pendValid;
  logic [LEN_W-1:0] pendLast;
  logic [LEN_W-1:0] curLast;
  logic [LEN_W-1:0] bitCnt;
  logic             twoBytes;
  logic             accept;
  logic             lastBit;

  assign effLen    = (int'(charLen) < MIN_LEN) ? LEN_W'(MIN_LEN) : charLen;
  assign twoBytes  = int'(effLen) >= BYTE_W;
  assign byteReady = !pendValid;
  assign accept    = byteValid && byteReady;
  assign lastBit   = active && (bitCnt == curLast);

  always_comb begin
    stb.captureLow  = accept && twoBytes && !haveLow;
    stb.capturePend = accept && !(twoBytes && !haveLow);
    stb.loadShift   = pendValid && (!active || lastBit);
    stb.shiftEn     = active;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveLow   <= 1'b0;
      pendValid <= 1'b0;
      pendLast  <= '0;
      curLast   <= '0;
      bitCnt    <= '0;
      active    <= 1'b0;
    end else begin
      if (stb.captureLow)       haveLow <= 1'b1;
      else if (stb.capturePend) haveLow <= 1'b0;

      if (stb.capturePend) begin
        pendValid <= 1'b1;
        pendLast  <= effLen;
      end else if (stb.loadShift) begin
        pendValid <= 1'b0;
      end

      if (stb.loadShift) begin
        curLast <= pendLast;
        bitCnt  <= '0;
        active  <= 1'b1;
      end else if (lastBit) begin
        active  <= 1'b0;
      end else if (active) begin
        bitCnt  <= bitCnt + 1'b1;
      end
    end
  end

  // R2
  bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (bitCnt <= curLast));

  // R2
  bit_count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !lastBit) |=> (active && bitCnt == $past(bitCnt) + 1'b1));

  // R8
  no_idle_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastBit && pendValid) |=> (active && bitCnt == '0));

  // R10
  start_needs_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(pendValid));

  // R5
  low_byte_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.captureLow |=> haveLow);
endmodule

// File: rtl/spi_ser_dpath.sv
module spi_ser_dpath
  import spi_ser_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  serStrobes_t       stb,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [LEN_W-1:0]  effLen,
  input  logic              revOrder,
  output logic              serOut
);
  localparam int MAX_W = 2 * BYTE_W;
  localparam int IDX_W = $clog2(MAX_W);

  logic [BYTE_W-1:0] lowByte;
  logic [MAX_W-1:0]  rawWord;
  logic [MAX_W-1:0]  maskedWord;
  logic [MAX_W-1:0]  mirrorWord;
  logic [MAX_W-1:0]  pendWord;
  logic [MAX_W-1:0]  shiftReg;

  assign rawWord = (int'(effLen) >= BYTE_W) ? {byteData, lowByte}
                                            : {{BYTE_W{1'b0}}, byteData};

  for (genvar g = 0; g < MAX_W; g++) begin : g_bit
    logic [IDX_W-1:0] srcIdx;
    assign srcIdx        = IDX_W'(int'(effLen) - g);
    assign maskedWord[g] = (g <= int'(effLen)) ? rawWord[g] : 1'b0;
    assign mirrorWord[g] = (g <= int'(effLen)) ? rawWord[srcIdx] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowByte  <= '0;
      pendWord <= '0;
      shiftReg <= '0;
    end else begin
      if (stb.captureLow)  lowByte  <= byteData;
      if (stb.capturePend) pendWord <= revOrder ? mirrorWord : maskedWord;
      if (stb.loadShift)   shiftReg <= pendWord;
      else if (stb.shiftEn) shiftReg <= shiftReg >> 1;
    end
  end

  assign serOut = shiftReg[0];

  // R6
  first_bit_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadShift |=> (serOut == $past(pendWord[0])));

  // R2
  line_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.shiftEn && !stb.loadShift) |=> $stable(shiftReg));
endmodule

// File: rtl/spi_char_serializer.sv
module spi_char_serializer
  import spi_ser_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              byteValid,
  output logic              byteReady,
  input  logic [LEN_W-1:0]  charLen,
  input  logic              revOrder,
  output logic              serOut,
  output logic              shiftStb,
  output logic              busy
);
  serStrobes_t      stb;
  logic [LEN_W-1:0] effLen;
  logic             active;

  spi_ser_ctrl #(.BYTE_W(BYTE_W), .LEN_W(LEN_W), .MIN_LEN(3)) ctrl_i (
    .clk(clk), .rstN(rstN), .charLen(charLen), .byteValid(byteValid),
    .byteReady(byteReady), .effLen(effLen), .stb(stb), .active(active)
  );

  spi_ser_dpath #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .byteData(byteData),
    .effLen(effLen), .revOrder(revOrder), .serOut(serOut)
  );

  assign shiftStb = active;
  assign busy     = active;
endmodule

// File: tb/spi_char_serializer_tb.sv
module spi_char_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] byteData = '0;
  logic       byteValid = 1'b0;
  logic       byteReady;
  logic [3:0] charLen = 4'd7;
  logic       revOrder = 1'b0;
  logic       serOut, shiftStb, busy;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spi_char_serializer dut_i (
    .clk(clk), .rstN(rstN), .byteData(byteData), .byteValid(byteValid),
    .byteReady(byteReady), .charLen(charLen), .revOrder(revOrder),
    .serOut(serOut), .shiftStb(shiftStb), .busy(busy)
  );

  // bit monitor
  int       cyc = 0;
  bit       monOn = 1'b0;
  logic     gotBit [0:511];
  int       stamp  [0:511];
  int       nGot = 0;
  int       busyBad = 0;
  logic [7:0] txBuf [0:31];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (monOn) begin
    if (shiftStb) begin
      gotBit[nGot] = serOut;
      stamp[nGot]  = cyc;
      nGot++;
    end
    if (busy !== shiftStb) busyBad++;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic putByte(input logic [7:0] d);
    @(negedge clk);
    byteData  = d;
    byteValid = 1'b1;
    while (!byteReady) @(negedge clk);
  endtask

  task automatic dropValid();
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  // Expected line bits computed from the requirements and compared with the monitor
  task automatic runCase(input string req, input int lenCfg, input bit rev,
                         input int nBytes, input int stallCyc);
    int n, perChar, nChars, expTotal, bad, gaps, pos;
    logic [15:0] val;
    n       = ((lenCfg < 3) ? 3 : lenCfg) + 1;
    perChar = (n > 8) ? 2 : 1;
    nChars  = nBytes / perChar;
    @(negedge clk);
    charLen  = 4'(lenCfg);
    revOrder = rev;
    nGot = 0; busyBad = 0; monOn = 1'b1;
    for (int b = 0; b < nBytes; b++) begin
      putByte(txBuf[b]);
      if (stallCyc > 0) begin
        dropValid();
        repeat (stallCyc) @(negedge clk);
      end
    end
    dropValid();
    repeat (2 * n * nChars + 40) @(negedge clk);
    monOn = 1'b0;
    expTotal = n * nChars;
    check(req, "bit count", nGot, expTotal);
    bad = 0; pos = 0;
    for (int c = 0; c < nChars; c++) begin
      val = (perChar == 2) ? {txBuf[2*c+1], txBuf[2*c]} : {8'h00, txBuf[c]};
      for (int k = 0; k < n; k++) begin
        logic e;
        e = rev ? val[n-1-k] : val[k];
        if (pos < nGot && gotBit[pos] !== e) bad++;
        pos++;
      end
    end
    check(req, "bit mismatches", bad, 0);
    check("R9", "busy vs strobe mismatches", busyBad, 0);
    check("R9", "busy low after stream", int'(busy), 0);
    if (stallCyc == 0) begin
      gaps = 0;
      for (int i = 1; i < nGot; i++) if (stamp[i] != stamp[i-1] + 1) gaps++;
      check("R8", "gaps in continuous stream", gaps, 0);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "serOut", int'(serOut), 0);
    check("R1", "shiftStb", int'(shiftStb), 0);
    check("R1", "busy", int'(busy), 0);
    check("R1", "byteReady", int'(byteReady), 1);
  endtask

  task automatic testByteChars();
    txBuf[0] = 8'hA5; txBuf[1] = 8'h3C; txBuf[2] = 8'h0F; txBuf[3] = 8'h81;
    runCase("R4 R6", 7, 1'b0, 4, 0);
    runCase("R4 R7", 7, 1'b1, 4, 0);
  endtask

  task automatic testHalfWordChars();
    txBuf[0] = 8'h96; txBuf[1] = 8'hFB; txBuf[2] = 8'h01; txBuf[3] = 8'hE0;
    txBuf[4] = 8'h7E; txBuf[5] = 8'h15;
    runCase("R5 R6", 12, 1'b0, 6, 0);
    runCase("R5 R7", 12, 1'b1, 6, 0);
  endtask

  task automatic testShortLen();
    txBuf[0] = 8'hF9; txBuf[1] = 8'h36; txBuf[2] = 8'hA2; txBuf[3] = 8'h5D;
    runCase("R3 R4", 1, 1'b0, 4, 0);
    runCase("R3 R7", 0, 1'b1, 4, 0);
    runCase("R4 R7", 5, 1'b1, 4, 0);
  endtask

  task automatic testLenSweep();
    txBuf[0] = 8'h5A; txBuf[1] = 8'hC3; txBuf[2] = 8'h2D; txBuf[3] = 8'hB4;
    for (int l = 3; l <= 15; l++) runCase("R2", l, l[0], 4, 0);
  endtask

  task automatic testStall();
    int strobes;
    txBuf[0] = 8'h4B; txBuf[1] = 8'hD2; txBuf[2] = 8'h9E; txBuf[3] = 8'h07;
    runCase("R10", 9, 1'b0, 4, 25);
    strobes = 0;
    byteData = 8'hFF;
    repeat (20) begin
      @(negedge clk);
      if (shiftStb) strobes++;
    end
    check("R10", "strobes with valid low", strobes, 0);
    check("R10", "byteReady while idle", int'(byteReady), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testByteChars();
    testHalfWordChars();
    testShortLen();
    testLenSweep();
    testStall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule